// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

The block runs a general-purpose I/O port of parameterised width, eight bits by default. A simple single-cycle register bus reaches three registers: an output data latch, a per-bit direction register and a per-bit pullup request register. For each pin the block drives three pad signals: a tri-state enable, an output value and a pullup request. It also takes back one sampled input level per pin.

Pin levels pass through a synchronizer chain before they reach the read path. A read of the data register returns, bit by bit, either the latch or the synchronized pin, depending on that bit's direction. The latch takes every write, whatever the direction. A value written while a bit is an input stays hidden until that bit becomes an output. A pullup is never requested on a pin that is driving.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch, direction and pullup registers all hold zero, and `pad_oe`, `pad_out` and `pad_pull` are all zero, so every pin is a high-impedance input.
- R2: A read of the data register (offset 0x00) returns, for each bit, the latch bit when the direction bit is 1 and the synchronized pin level when it is 0.
- R3: A write to offset 0x00 always updates the latch, whatever the direction bits are. Bits that are inputs read back the pin, not the new latch value, until their direction becomes output.
- R4: The direction register (offset 0x04, 1 = output) reads back the last value written to it.
- R5: `pad_pull` of a bit is 1 only when its pullup enable bit is 1 and its direction bit is 0. Setting the direction bit turns the pullup off in the cycle after the write.
- R6: The pullup enable register (offset 0x0D) reads back its stored value, including bits whose pullup is forced off by output mode.
- R7: `pad_oe` equals the direction register and `pad_out` equals the latch, both updated on the clock edge that takes the write.
- R8: A pin change made just before clock edge k becomes visible to a read whose data is captured on edge k+2. Reads captured on edges k and k+1 still return the old level.
- R9: Any offset other than 0x00, 0x04 and 0x0D reads as zero, and a write to it changes no register.
- R10: `bus_rdata` is registered: it carries the addressed value in the cycle after `bus_rd` is high, and zero after any cycle in which `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Registered read data |
| pin_in | input | WIDTH (8) | Sampled pad levels, asynchronous |
| pad_oe | output | WIDTH (8) | Per-pin output driver enable |
| pad_out | output | WIDTH (8) | Per-pin output value |
| pad_pull | output | WIDTH (8) | Per-pin pullup request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, and that the bus inputs are stable around each rising edge. The pin inputs may change at any time, because they only reach the synchronizer. The bench drives all bus and pin signals on falling edges and issues one access per cycle. Its pin model resolves each pin from the pad outputs and an external driver, so a pin changes level only through a pad enable, a pullup request or an explicit external drive.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_PULL = 2'd3
   } reg_sel_t;

   function automatic reg_sel_t decode_sel(input int addr, input int data_ofs,
                                           input int dir_ofs, input int pull_ofs);
      if (addr == data_ofs)      return SEL_DATA;
      else if (addr == dir_ofs)  return SEL_DIR;
      else if (addr == pull_ofs) return SEL_PULL;
      else                       return SEL_NONE;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int ADDR_W   = 4,
   parameter int DATA_OFS = 0,
   parameter int DIR_OFS  = 4,
   parameter int PULL_OFS = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  pull_en_q
);

   reg_sel_t sel;

   always_comb sel = decode_sel(int'(addr), DATA_OFS, DIR_OFS, PULL_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q   <= '0;
         dir_q     <= '0;
         pull_en_q <= '0;
      end else if (wr) begin
         unique case (sel)
            SEL_DATA: latch_q   <= wdata;
            SEL_DIR:  dir_q     <= wdata;
            SEL_PULL: pull_en_q <= wdata;
            default:  ;
         endcase
      end
   end

   // R3: latch follows every data write, regardless of direction
   p_latch_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && int'(addr) == DATA_OFS) |=> latch_q == $past(wdata));

   // R4: direction register holds what was written
   p_dir_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && int'(addr) == DIR_OFS) |=> dir_q == $past(wdata));

   // R6: pullup enable register stores the written value
   p_pull_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && int'(addr) == PULL_OFS) |=> pull_en_q == $past(wdata));

   // R9: writes to unmapped offsets leave every register untouched
   p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && int'(addr) != DATA_OFS && int'(addr) != DIR_OFS && int'(addr) != PULL_OFS)
      |=> ($stable(latch_q) && $stable(dir_q) && $stable(pull_en_q)));

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pull_en_q,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pull
);

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_pin
         assign pad_oe[b]   = dir_q[b];
         assign pad_out[b]  = latch_q[b];
         assign pad_pull[b] = pull_en_q[b] & ~dir_q[b];

         // R5: a driving pin never requests its pullup
         p_pull_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[b] |-> !pad_pull[b]);
      end
   endgenerate

endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
   import gpio_port_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int ADDR_W   = 4,
   parameter int DATA_OFS = 0,
   parameter int DIR_OFS  = 4,
   parameter int PULL_OFS = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic [WIDTH-1:0]  latch_q,
   input  logic [WIDTH-1:0]  dir_q,
   input  logic [WIDTH-1:0]  pull_en_q,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  rdata
);

   reg_sel_t         sel;
   logic [WIDTH-1:0] port_view;
   logic [WIDTH-1:0] rd_val;

   always_comb sel = decode_sel(int'(addr), DATA_OFS, DIR_OFS, PULL_OFS);

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_mix
         assign port_view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_DATA: rd_val = port_view;
         SEL_DIR:  rd_val = dir_q;
         SEL_PULL: rd_val = pull_en_q;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_val;
      else         rdata <= '0;
   end

   // R10: no read strobe, no data
   p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> rdata == '0);

   // R9: unmapped offsets read as zero
   p_rd_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && int'(addr) != DATA_OFS && int'(addr) != DIR_OFS && int'(addr) != PULL_OFS)
      |=> rdata == '0);

   // R2: output bits return the latch
   p_rd_out_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && int'(addr) == DATA_OFS)
      |=> (rdata & $past(dir_q)) == ($past(latch_q) & $past(dir_q)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
   parameter int WIDTH       = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_OFS    = 0,
   parameter int DIR_OFS     = 4,
   parameter int PULL_OFS    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_pull
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_port: WIDTH must be positive");
      end
      if (DATA_OFS >= ADDR_SPAN || DIR_OFS >= ADDR_SPAN || PULL_OFS >= ADDR_SPAN) begin : g_bad_ofs
         $error("gpio_port: register offset outside address space");
      end
      if (DATA_OFS == DIR_OFS || DATA_OFS == PULL_OFS || DIR_OFS == PULL_OFS) begin : g_dup_ofs
         $error("gpio_port: register offsets must differ");
      end
   endgenerate

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pull_en_q;
   logic [WIDTH-1:0] pin_sync;

   gpio_regs #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W),
      .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .PULL_OFS(PULL_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
      .latch_q(latch_q), .dir_q(dir_q), .pull_en_q(pull_en_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
   );

   gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
      .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .dir_q(dir_q), .pull_en_q(pull_en_q),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull)
   );

   gpio_rd_path #(
      .WIDTH(WIDTH), .ADDR_W(ADDR_W),
      .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .PULL_OFS(PULL_OFS)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd),
      .latch_q(latch_q), .dir_q(dir_q), .pull_en_q(pull_en_q), .pin_sync(pin_sync),
      .rdata(bus_rdata)
   );

   // R7: a direction write reaches the pad enable on the next edge
   p_oe_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && int'(bus_addr) == DIR_OFS) |=> pad_oe == $past(bus_wdata));

   // R5: setting a direction bit drops that pullup immediately
   p_pull_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && int'(bus_addr) == DIR_OFS) |=> (pad_pull & $past(bus_wdata)) == '0);

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

   localparam int W = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pin_in;
   logic [W-1:0] pad_oe, pad_out, pad_pull;
   logic [W-1:0] ext_en = '0;
   logic [W-1:0] ext_val = '0;

   int checks = 0;
   int fails  = 0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];
   logic         rd_seen = 1'b0;

   always #4 clk = ~clk;

   // pin model: driver wins, then external source, then pullup, else reads low
   assign pin_in = (pad_oe & pad_out) |
                   (~pad_oe & ((ext_en & ext_val) | (~ext_en & pad_pull)));

   gpio_port u_gpio_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // driver tasks: entered and left on a falling edge
   task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [W-1:0] exp, input string tag);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compare read data one cycle after each strobe
   always @(posedge clk) rd_seen <= bus_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: unexpected read data %02h", bus_rdata);
         end else begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      #1_000_000;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 pad_out", pad_out, 8'h00);
      check("R1 pad_pull", pad_pull, 8'h00);
      rd(4'h0, 8'h00, "R1 data");
      rd(4'h4, 8'h00, "R1 dir");
      rd(4'hD, 8'h00, "R1 pullup");

      // R5/R6: pullups on, floating inputs rise
      wr(4'hD, 8'hFF);
      check("R5 pull all inputs", pad_pull, 8'hFF);
      idle(2);
      rd(4'hD, 8'hFF, "R6 pullup readback");
      rd(4'h0, 8'hFF, "R2 pulled inputs");

      // R4/R5/R6/R7: low nibble becomes output
      wr(4'h4, 8'h0F);
      check("R7 pad_oe", pad_oe, 8'h0F);
      check("R5 pull forced off", pad_pull, 8'hF0);
      rd(4'h4, 8'h0F, "R4 dir readback");
      rd(4'hD, 8'hFF, "R6 pullup kept");

      wr(4'h0, 8'hA5);
      check("R7 pad_out", pad_out, 8'hA5);
      idle(2);
      rd(4'h0, 8'hF5, "R2 mixed read");

      // R2: external drive on input nibble
      ext_en = 8'hF0; ext_val = 8'h30;
      idle(3);
      rd(4'h0, 8'h35, "R2 external input");

      // R3: latch writes while inputs stay hidden
      wr(4'h0, 8'h00);
      rd(4'h0, 8'h30, "R3 input unaffected");
      wr(4'h0, 8'hC0);
      check("R3 latch took write", pad_out, 8'hC0);
      rd(4'h0, 8'h30, "R3 hidden latch");
      wr(4'h4, 8'hFF);
      check("R5 all outputs no pull", pad_pull, 8'h00);
      idle(2);
      rd(4'h0, 8'hC0, "R3 latch revealed");

      // R9: unmapped offsets
      wr(4'h1, 8'h5A);
      wr(4'hF, 8'h5A);
      rd(4'h1, 8'h00, "R9 unmapped read");
      rd(4'h0, 8'hC0, "R9 data kept");
      rd(4'h4, 8'hFF, "R9 dir kept");
      rd(4'hD, 8'hFF, "R9 pullup kept");

      // R10: idle read bus
      idle(1);
      check("R10 idle rdata", bus_rdata, 8'h00);

      // R8: synchronizer latency
      wr(4'h4, 8'h00);
      ext_en = 8'hFF; ext_val = 8'h00;
      idle(3);
      rd(4'h0, 8'h00, "R8 settled low");
      ext_val = 8'hFF;
      rd(4'h0, 8'h00, "R8 edge k");
      rd(4'h0, 8'h00, "R8 edge k+1");
      rd(4'h0, 8'hFF, "R8 edge k+2");

      idle(2);
      if (exp_q.size() != 0) begin
         checks++; fails++;
         $display("FAIL scoreboard: %0d reads never returned", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule